// File: doc/BRIEF.md
# Saturating Wiper Position Controller

This block steers a digitally adjusted tap selector over three asynchronous control lines: an active-low select (`cs_n`), a step strobe (`inc`) and a direction level (`dir_up`). While the block is selected, each falling edge of the strobe moves a 7-bit position one place up or down. The position stops at either end and does not wrap. The position is decoded into a one-hot select across all taps. The controller owns a retained position register that models nonvolatile storage.

When `cs_n` rises, the level of `inc` at that moment decides what happens. If `inc` is high, the live position is written into the retained register and a self-timed busy period starts. The block ignores its inputs for the whole of that period. If `inc` is low, the block only deselects. The new position stays in use but is not saved. A power-up reset (`rst_n`) brings the live position back from the retained register. A separate cold reset (`cold_rst_n`) stands for first-ever power. It sets the retained register to a factory value.

All three control lines pass through two-flop synchronisers before any edge is detected. A change on a control line therefore reaches `wiper_pos` on the third rising clock edge.

Top module: `wpc_ctrl`

## Requirements
- R1: On the first clock after `rst_n` is released, `wiper_pos` takes the retained value. After a cold reset that value is `INIT_POS` (default 64). `busy` is 0 after reset.
- R2: `tap_sel` always has exactly one bit set, and that bit sits at index `wiper_pos`.
- R3: While `cs_n` is low, a falling edge of `inc` moves `wiper_pos` by one step. The step is +1 when `dir_up` is 1 and −1 when `dir_up` is 0.
- R4: A rising edge of `inc` never moves the position. `inc` edges while `cs_n` is high never move the position.
- R5: `dir_up` may change between steps inside one selected session, and each step follows the current level of `dir_up`.
- R6: An up step at 127 leaves 127, and a down step at 0 leaves 0. The position never wraps.
- R7: A rising `cs_n` with `inc` high saves `wiper_pos` into the retained register. `busy` is then high for exactly `STORE_CYCLES` clock cycles.
- R8: A rising `cs_n` with `inc` low saves nothing and raises no `busy`. The live position stays in use until the next power-up reset, which restores the previously saved value.
- R9: While `busy` is high, the block ignores `inc` edges and `cs_n` activity. The position does not move and no new save starts.
- R10: A falling `inc` edge changes `wiper_pos` on the third rising clock edge after the input changes, not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| cold_rst_n | input | 1 | Active-low cold reset; loads the retained register with `INIT_POS` |
| rst_n | input | 1 | Active-low power-up reset; the position is recalled when it is released |
| cs_n | input | 1 | Active-low select; a rising edge ends the session |
| inc | input | 1 | Step strobe; a falling edge steps the position |
| dir_up | input | 1 | Step direction: 1 up, 0 down |
| wiper_pos | output | POS_W | Current position |
| tap_sel | output | 2**POS_W | One-hot tap select |
| busy | output | 1 | High during the self-timed save |

## Verification
The bench drives the position into both ends and keeps pushing there. A counter that wrapped would show 0 after 127, or 127 after 0. It ends sessions both ways. A design that sampled the wrong `inc` level at deselect would save a no-save session, or skip a save, and a power-up reset exposes either error. During `busy` the bench reselects the block, toggles the strobe and deselects it again. A design that let those inputs through would move the position or restart the save. One directed step is sampled one cycle before and on the cycle it is due, so an added or missing synchroniser stage is caught.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

  typedef enum logic {NV_IDLE, NV_BUSY} nv_state_e;

  // Saturating one-place move inside [0, max_pos].
  function automatic int unsigned sat_step(int unsigned pos, int unsigned max_pos, logic up);
    if (up) return (pos >= max_pos) ? max_pos : pos + 1;
    return (pos == 0) ? 0 : pos - 1;
  endfunction

  // True when tap index idx is the selected one.
  function automatic logic tap_hit(int unsigned pos, int unsigned idx);
    return pos == idx;
  endfunction

endpackage

// File: rtl/wpc_sync.sv
module wpc_sync #(
  parameter int unsigned     W       = 1,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1, stage2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= RST_VAL;
      stage2 <= RST_VAL;
    end else begin
      stage1 <= d;
      stage2 <= stage1;
    end
  end

  assign q = stage2;
endmodule

// File: rtl/wpc_counter.sv
module wpc_counter #(
  parameter int unsigned POS_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [POS_W-1:0] load_val,
  input  logic             step,
  input  logic             up,
  output logic [POS_W-1:0] pos
);
  localparam int unsigned MAX_POS = (1 << POS_W) - 1;

  logic [POS_W-1:0] pos_q, pos_d;

  always_comb begin
    pos_d = pos_q;
    if (load)      pos_d = load_val;
    else if (step) pos_d = POS_W'(wpc_pkg::sat_step(32'(pos_q), MAX_POS, up));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_d;
  end

  assign pos = pos_q;
endmodule

// File: rtl/wpc_nvstore.sv
module wpc_nvstore #(
  parameter int unsigned POS_W        = 7,
  parameter int unsigned STORE_CYCLES = 1_000_000,
  parameter int unsigned INIT_POS     = 64
) (
  input  logic             clk,
  input  logic             cold_rst_n,
  input  logic             rst_n,
  input  logic             start,
  input  logic [POS_W-1:0] wr_val,
  output logic [POS_W-1:0] nv_val,
  output logic             busy
);
  import wpc_pkg::*;

  localparam int unsigned TMR_W = $clog2(STORE_CYCLES + 1);

  nv_state_e        state;
  logic [TMR_W-1:0] tmr;
  logic [POS_W-1:0] nv_q;

  // Retained cell: only a cold start clears it.
  always_ff @(posedge clk or negedge cold_rst_n) begin
    if (!cold_rst_n)                    nv_q <= POS_W'(INIT_POS);
    else if (start && state == NV_IDLE) nv_q <= wr_val;
  end

  // Self-timed save window.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= NV_IDLE;
      tmr   <= '0;
    end else begin
      case (state)
        NV_IDLE: if (start) begin
          state <= NV_BUSY;
          tmr   <= TMR_W'(STORE_CYCLES - 1);
        end
        NV_BUSY: begin
          if (tmr == '0) state <= NV_IDLE;
          else           tmr   <= tmr - TMR_W'(1);
        end
        default: state <= NV_IDLE;
      endcase
    end
  end

  assign nv_val = nv_q;
  assign busy   = (state == NV_BUSY);
endmodule

// File: rtl/wpc_decode.sv
module wpc_decode #(
  parameter int unsigned POS_W = 7
) (
  input  logic [POS_W-1:0]        pos,
  output logic [(1<<POS_W)-1:0]   sel
);
  localparam int unsigned TAPS = 1 << POS_W;

  for (genvar i = 0; i < TAPS; i++) begin : g_tap
    assign sel[i] = wpc_pkg::tap_hit(32'(pos), i);
  end
endmodule

// File: rtl/wpc_ctrl.sv
module wpc_ctrl #(
  parameter int unsigned POS_W        = 7,
  parameter int unsigned STORE_CYCLES = 1_000_000,
  parameter int unsigned INIT_POS     = 64
) (
  input  logic                    clk,
  input  logic                    cold_rst_n,
  input  logic                    rst_n,
  input  logic                    cs_n,
  input  logic                    inc,
  input  logic                    dir_up,
  output logic [POS_W-1:0]        wiper_pos,
  output logic [(1<<POS_W)-1:0]   tap_sel,
  output logic                    busy
);
  // bit 0 select, bit 1 strobe, bit 2 direction; idle levels 1,1,0
  logic [2:0] sync_q;
  logic       cs_s, inc_s, dir_s;
  logic       cs_prev, inc_prev, recall_q;
  logic       cs_rise, inc_fall;
  logic       step_ev, store_ev;
  logic [POS_W-1:0] nv_val;

  wpc_sync #(.W(3), .RST_VAL(3'b011)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({dir_up, inc, cs_n}), .q(sync_q)
  );

  assign cs_s  = sync_q[0];
  assign inc_s = sync_q[1];
  assign dir_s = sync_q[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_prev  <= 1'b1;
      inc_prev <= 1'b1;
      recall_q <= 1'b1;
    end else begin
      cs_prev  <= cs_s;
      inc_prev <= inc_s;
      recall_q <= 1'b0;
    end
  end

  // Named events for the checker.
  assign cs_rise  = ~cs_prev & cs_s;
  assign inc_fall = inc_prev & ~inc_s;
  assign step_ev  = inc_fall & ~cs_s & ~busy & ~recall_q;
  assign store_ev = cs_rise & inc_s & ~busy & ~recall_q;

  wpc_counter #(.POS_W(POS_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(recall_q), .load_val(nv_val),
    .step(step_ev), .up(dir_s), .pos(wiper_pos)
  );

  wpc_nvstore #(.POS_W(POS_W), .STORE_CYCLES(STORE_CYCLES), .INIT_POS(INIT_POS)) u_nv (
    .clk(clk), .cold_rst_n(cold_rst_n), .rst_n(rst_n), .start(store_ev),
    .wr_val(wiper_pos), .nv_val(nv_val), .busy(busy)
  );

  wpc_decode #(.POS_W(POS_W)) u_dec (
    .pos(wiper_pos), .sel(tap_sel)
  );
endmodule

// File: rtl/wpc_ctrl_chk.sv
module wpc_ctrl_chk #(
  parameter int unsigned POS_W        = 7,
  parameter int unsigned STORE_CYCLES = 1_000_000
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cold_rst_n,
  input logic [POS_W-1:0]      wiper_pos,
  input logic [(1<<POS_W)-1:0] tap_sel,
  input logic                  busy,
  input logic                  step_ev,
  input logic                  store_ev,
  input logic                  recall_q,
  input logic [POS_W-1:0]      nv_val
);
  localparam int unsigned MAX_POS = (1 << POS_W) - 1;
  localparam int unsigned LEN_W   = $clog2(STORE_CYCLES + 2);

  logic [LEN_W-1:0] busy_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_len <= '0;
    else if (busy) busy_len <= busy_len + LEN_W'(1);
    else           busy_len <= '0;
  end

  // R2
  tap_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tap_sel) == 1);
  // R2
  tap_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tap_sel[wiper_pos] == 1'b1);
  // R6
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !recall_q |=> (wiper_pos == $past(wiper_pos) ||
                   32'(wiper_pos) == 32'($past(wiper_pos)) + 1 ||
                   32'(wiper_pos) + 1 == 32'($past(wiper_pos))));
  // R3
  step_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_ev && 32'(wiper_pos) != 0 && 32'(wiper_pos) != MAX_POS)
      |=> wiper_pos != $past(wiper_pos));
  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(wiper_pos));
  // R7
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(store_ev));
  // R7
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_len <= LEN_W'(STORE_CYCLES));
  // R8
  nv_stable_chk: assert property (@(posedge clk) disable iff (!rst_n || !cold_rst_n)
    !store_ev |=> $stable(nv_val));
endmodule

bind wpc_ctrl wpc_ctrl_chk #(.POS_W(POS_W), .STORE_CYCLES(STORE_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cold_rst_n(cold_rst_n), .wiper_pos(wiper_pos),
  .tap_sel(tap_sel), .busy(busy), .step_ev(step_ev), .store_ev(store_ev),
  .recall_q(recall_q), .nv_val(nv_val)
);

// File: tb/wpc_ctrl_test.sv
module wpc_ctrl_test;
  localparam int unsigned POS_W   = 7;
  localparam int unsigned STORE_T = 20;
  localparam int unsigned INIT_P  = 64;
  localparam int          MAXP    = (1 << POS_W) - 1;

  logic clk = 1'b0;
  logic cold_rst_n = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, inc = 1'b1, dir_up = 1'b0;
  logic [POS_W-1:0]      wiper_pos;
  logic [(1<<POS_W)-1:0] tap_sel;
  logic                  busy;

  int n_chk = 0, n_fail = 0;
  int exp_pos, exp_nv;

  always #10 clk = ~clk;

  wpc_ctrl #(.POS_W(POS_W), .STORE_CYCLES(STORE_T), .INIT_POS(INIT_P)) uut (
    .clk(clk), .cold_rst_n(cold_rst_n), .rst_n(rst_n), .cs_n(cs_n), .inc(inc),
    .dir_up(dir_up), .wiper_pos(wiper_pos), .tap_sel(tap_sel), .busy(busy)
  );

  function automatic int model_step(int p, bit up);
    if (up) return (p >= MAXP) ? MAXP : p + 1;
    return (p <= 0) ? 0 : p - 1;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_pos(string req);
    chk(int'(wiper_pos) == exp_pos, req, int'(wiper_pos), exp_pos);
    chk(tap_sel == ((1<<POS_W)'(1) << exp_pos), "R2 one-hot tap", $countones(tap_sel), 1);
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic select_dev();
    @(negedge clk); cs_n = 1'b0; wait_cyc(4);
  endtask

  task automatic pulse(bit d, string req);
    @(negedge clk); dir_up = d; wait_cyc(3);
    inc = 1'b0; wait_cyc(4);
    exp_pos = model_step(exp_pos, d);
    check_pos(req);
    inc = 1'b1; wait_cyc(3);
  endtask

  task automatic end_nostore(bit d);
    @(negedge clk); dir_up = d; wait_cyc(3);
    inc = 1'b0; wait_cyc(4);
    exp_pos = model_step(exp_pos, d);
    cs_n = 1'b1; wait_cyc(4);
    inc = 1'b1; wait_cyc(4);
    // R8: no save window opened, position kept
    chk(busy == 1'b0, "R8 no busy", int'(busy), 0);
    check_pos("R8 position kept");
  endtask

  task automatic end_store();
    @(negedge clk); cs_n = 1'b1;
    exp_nv = exp_pos;
    wait_cyc(STORE_T + 8);
    chk(busy == 1'b0, "R7 busy ended", int'(busy), 0);
  endtask

  task automatic power_cycle(string req);
    @(negedge clk); rst_n = 1'b0; wait_cyc(2);
    rst_n = 1'b1; wait_cyc(3);
    exp_pos = exp_nv;
    check_pos(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int cnt;
    void'($urandom(32'h5EED1234));
    wait_cyc(3);
    cold_rst_n = 1'b1; rst_n = 1'b1;
    wait_cyc(4);
    exp_nv = INIT_P; exp_pos = INIT_P;
    // R1: recall of factory value
    check_pos("R1 recall after cold start");
    chk(busy == 1'b0, "R1 busy idle", int'(busy), 0);

    // R4: strobe while deselected
    @(negedge clk); inc = 1'b0; wait_cyc(4); inc = 1'b1; wait_cyc(4);
    check_pos("R4 deselected strobe");

    // R10: latency of a step
    select_dev();
    dir_up = 1'b1; wait_cyc(4);
    inc = 1'b0; wait_cyc(2);
    check_pos("R10 not before third edge");
    wait_cyc(1);
    exp_pos = model_step(exp_pos, 1'b1);
    check_pos("R10 on third edge (R3 up)");
    inc = 1'b1; wait_cyc(4);
    check_pos("R4 rising strobe no step");

    // R5 / R3: direction change within session
    pulse(1'b0, "R5 down after up (R3)");
    pulse(1'b0, "R3 down");
    pulse(1'b1, "R5 up again");

    // R6: top saturation
    for (int i = 0; i < 70; i++) pulse(1'b1, "R6 upward run");
    chk(int'(wiper_pos) == MAXP, "R6 top end", int'(wiper_pos), MAXP);

    // R7: save with busy length
    @(negedge clk); cs_n = 1'b1; exp_nv = exp_pos;
    cnt = 0;
    for (int i = 0; i < STORE_T + 10; i++) begin
      @(negedge clk);
      if (busy) cnt++;
    end
    chk(cnt == STORE_T, "R7 busy length", cnt, STORE_T);
    power_cycle("R7 saved top recalled (R1)");

    // R6: bottom saturation
    select_dev();
    for (int i = 0; i < 130; i++) pulse(1'b0, "R6 downward run");
    chk(int'(wiper_pos) == 0, "R6 bottom end", int'(wiper_pos), 0);

    // R9: activity during save is ignored
    @(negedge clk); cs_n = 1'b1; exp_nv = exp_pos;
    wait_cyc(4);
    chk(busy == 1'b1, "R9 busy during save", int'(busy), 1);
    cs_n = 1'b0; wait_cyc(3);
    dir_up = 1'b1; inc = 1'b0; wait_cyc(3);
    inc = 1'b1; wait_cyc(3);
    cs_n = 1'b1; wait_cyc(3);
    chk(busy == 1'b1, "R9 still busy", int'(busy), 1);
    check_pos("R9 no step while busy");
    wait_cyc(STORE_T + 8);
    chk(busy == 1'b0, "R9 no restarted save", int'(busy), 0);
    check_pos("R9 position after save");

    // R8: session closed without save
    select_dev();
    for (int i = 0; i < 5; i++) pulse(1'b1, "R8 move before no-save");
    end_nostore(1'b1);
    chk(exp_pos == 6, "R8 live value", exp_pos, 6);
    power_cycle("R8 old value recalled");

    // Random sessions
    for (int s = 0; s < 25; s++) begin
      int n;
      select_dev();
      n = $urandom_range(1, 20);
      for (int k = 0; k < n; k++) pulse(1'($urandom_range(0, 1)), "R3 random step");
      if ($urandom_range(0, 1) == 1) end_store();
      else end_nostore(1'($urandom_range(0, 1)));
      if ($urandom_range(0, 3) == 0) power_cycle("R1 random recall");
    end
    power_cycle("R8 final recall");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule